// File: doc/BRIEF.md
# Widening Bottom/Top Vector Multiplier

This block multiplies two 128-bit source vectors lane by lane and produces a vector of double-width products. A widening operation picks either the even-numbered lanes (bottom form) or the odd-numbered lanes (top form) of both sources. It multiplies each selected pair, and the full-width product occupies two adjacent destination lanes. Three arithmetic kinds are offered: carry-less polynomial, signed two's complement and unsigned. A separate non-widening polynomial mode multiplies every byte lane and keeps only the low byte of each carry-less product.

An operation begins with a one-cycle `start_i`. The block latches the operands and the decoded operation, then handles one multiplier bit per clock in all lanes at once. It pulses `done_o` when the result is ready. If the opcode/size pair has no defined meaning, the block does no work. It finishes at once with a zero result and raises `undef_o`. The result and the flag hold their values until the next accepted start.

Top module: `wbt_mul`

## Requirements
- R1: In widening mode (`narrow_i`=0), `opc_i` picks the operation: 2 is polynomial bottom, 3 is polynomial top, 4 is signed bottom, 5 is signed top, 6 is unsigned bottom and 7 is unsigned top. Codes 0 and 1 are undefined.
- R2: Bottom forms read source lane 2i and top forms read source lane 2i+1, for i from 0 to VLEN/(2E)-1, where E is the source lane width.
- R3: The 2E-bit product of pair i is written to result bits [2E·i +: 2E]. Its low half goes to destination lane 2i and its high half to lane 2i+1.
- R4: In polynomial mode the partial products are combined by XOR: for every set bit j of the source-A element, the source-B element shifted left by j is XORed into the product.
- R5: Signed mode treats both elements as two's complement. It accepts `size_i` 1, 2 and 3, which give E of 8, 16 and 32 bits.
- R6: Unsigned mode accepts `size_i` 1, 2 and 3, which give E of 8, 16 and 32 bits. `size_i`=0 is undefined for both signed and unsigned mode.
- R7: Polynomial widening mode accepts `size_i`=1 (E=8) and `size_i`=3 (E=32). `size_i` 0 and 2 are undefined for it.
- R8: With `narrow_i`=1 the block ignores `opc_i` and needs `size_i`=0. It multiplies all 16 byte lanes carry-less and writes the low 8 bits of each product to the same lane. Any other size is undefined.
- R9: For a defined operation accepted on clock edge 0, `done_o` is high for exactly one cycle after edge E+1, with `undef_o`=0 and the product vector on `result_o`.
- R10: For an undefined encoding, `done_o` is high for one cycle after edge 0, `undef_o` is 1 and `result_o` is all zero.
- R11: A `start_i` that arrives while an operation is in progress has no effect. The operands and operation latched at the start are used even if the inputs change later, and `result_o`/`undef_o` hold until the next accepted start.
- R12: After synchronous reset, `done_o`, `undef_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| narrow_i | input | 1 | 1 selects the non-widening byte polynomial mode |
| opc_i | input | 3 | Widening operation code |
| size_i | input | 2 | Source lane width code |
| src_a_i | input | VLEN | First source vector (multiplier) |
| src_b_i | input | VLEN | Second source vector (multiplicand) |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Last operation had an undefined encoding |
| result_o | output | VLEN | Destination vector |

## Verification
The bench builds the block with its default 128-bit vector. At that size there are 8, 4 and 2 widening pairs for the three lane widths and 16 lanes in the byte polynomial mode, so each packing layout and each completion latency (9, 17 and 33 cycles) is reached. Operand patterns place sign bits and all-ones bytes in the selected lanes and different values in the unselected lanes. A bottom/top mix-up or a carry leaking into a polynomial product therefore shows up in the result.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    typedef enum logic [1:0] {
        K_POLY     = 2'd0,
        K_SIGNED   = 2'd1,
        K_UNSIGNED = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        W8  = 2'd0,
        W16 = 2'd1,
        W32 = 2'd2
    } width_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic   legal;
        logic   top;
        logic   narrow;
        kind_e  kind;
        width_e width;
    } op_cfg_t;

    // Widest source element the encodings can name.
    localparam int unsigned MAX_ELEM = 32;

    function automatic int unsigned width_bits(input width_e w);
        case (w)
            W16:     return 16;
            W32:     return 32;
            default: return 8;
        endcase
    endfunction

    function automatic op_cfg_t decode_op(input logic narrow,
                                          input logic [2:0] opc,
                                          input logic [1:0] size);
        op_cfg_t c;
        c        = '0;
        c.narrow = narrow;
        if (narrow) begin
            c.kind  = K_POLY;
            c.width = W8;
            c.legal = (size == 2'd0);
        end else begin
            c.top = opc[0];
            case (opc[2:1])
                2'b01: begin
                    c.kind  = K_POLY;
                    c.legal = (size == 2'd1) || (size == 2'd3);
                end
                2'b10: begin
                    c.kind  = K_SIGNED;
                    c.legal = (size != 2'd0);
                end
                2'b11: begin
                    c.kind  = K_UNSIGNED;
                    c.legal = (size != 2'd0);
                end
                default: c.legal = 1'b0;
            endcase
            case (size)
                2'd2:    c.width = W16;
                2'd3:    c.width = W32;
                default: c.width = W8;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/wbt_decode.sv
module wbt_decode
    import wbt_pkg::*;
(
    input  logic       narrow_i,
    input  logic [2:0] opc_i,
    input  logic [1:0] size_i,
    output op_cfg_t    cfg_o
);

    always_comb begin
        cfg_o = decode_op(narrow_i, opc_i, size_i);
        // R7: the 16-bit polynomial widening form has no meaning
        if (!narrow_i && (opc_i[2:1] == 2'b01) && (size_i == 2'd2)) begin
            p_poly_mid_size_r7: assert (!cfg_o.legal);
        end
    end

endmodule

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
    import wbt_pkg::*;
#(
    parameter int unsigned CNTW = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  op_cfg_t cfg_i,
    output op_cfg_t cfg_q_o,
    output logic    load_o,
    output logic    step_o,
    output logic    last_o,
    output logic    fin_o,
    output logic    rej_o
);

    state_e          state_q;
    logic [CNTW-1:0] cnt_q;
    op_cfg_t         cfg_q;
    logic            idle;
    logic [CNTW-1:0] top_bit;

    assign idle    = (state_q == S_IDLE);
    assign top_bit = CNTW'(width_bits(cfg_q.width) - 1);
    assign load_o  = idle && start_i && cfg_i.legal;
    assign rej_o   = idle && start_i && !cfg_i.legal;
    assign step_o  = (state_q == S_RUN);
    assign last_o  = step_o && (cnt_q == top_bit);
    assign fin_o   = (state_q == S_FIN);
    assign cfg_q_o = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (load_o) begin
                        state_q <= S_RUN;
                        cnt_q   <= '0;
                        cfg_q   <= cfg_i;
                    end
                end
                S_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_o) state_q <= S_FIN;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R9: the bit counter never runs past the element's top bit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (cnt_q <= top_bit));

    // R11: a start seen while busy leaves the latched operation unchanged
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!idle && start_i) |=> $stable(cfg_q));

endmodule

// File: rtl/wbt_lane.sv
module wbt_lane
    import wbt_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned PW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          last_i,
    input  kind_e         kind_i,
    input  logic [AW-1:0] a_i,
    input  logic [PW-1:0] b_i,
    output logic [PW-1:0] acc_o
);

    logic [AW-1:0] a_q;
    logic [PW-1:0] b_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] acc_nx;

    // One multiplier bit per step; the top bit of a signed element
    // carries negative weight, so it subtracts.
    always_comb begin
        acc_nx = acc_q;
        if (a_q[0]) begin
            case (kind_i)
                K_POLY:   acc_nx = acc_q ^ b_q;
                K_SIGNED: acc_nx = last_i ? (acc_q - b_q) : (acc_q + b_q);
                default:  acc_nx = acc_q + b_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else if (load_i) begin
            a_q   <= a_i;
            b_q   <= b_i;
            acc_q <= '0;
        end else if (step_i) begin
            a_q   <= a_q >> 1;
            b_q   <= b_q << 1;
            acc_q <= acc_nx;
        end
    end

    assign acc_o = acc_q;

    // R4: a clear multiplier bit adds no partial product
    p_zero_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && !a_q[0]) |=> $stable(acc_q));

endmodule

// File: rtl/wbt_mul.sv
module wbt_mul
    import wbt_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            narrow_i,
    input  logic [2:0]      opc_i,
    input  logic [1:0]      size_i,
    input  logic [VLEN-1:0] src_a_i,
    input  logic [VLEN-1:0] src_b_i,
    output logic            done_o,
    output logic            undef_o,
    output logic [VLEN-1:0] result_o
);

    localparam int unsigned AW   = MAX_ELEM;
    localparam int unsigned PW   = 2 * MAX_ELEM;
    localparam int unsigned NJOB = VLEN / 8;
    localparam int unsigned CNTW = $clog2(MAX_ELEM + 1);

    op_cfg_t cfg_in, cfg_q;
    logic    load, step, last, fin, rej;

    logic [AW-1:0]   job_a   [NJOB];
    logic [PW-1:0]   job_b   [NJOB];
    logic [PW-1:0]   job_acc [NJOB];
    logic [VLEN-1:0] packed_res;

    logic            done_q, undef_q;
    logic [VLEN-1:0] result_q;

    wbt_decode u_dec (
        .narrow_i (narrow_i),
        .opc_i    (opc_i),
        .size_i   (size_i),
        .cfg_o    (cfg_in)
    );

    wbt_ctrl #(.CNTW(CNTW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cfg_i   (cfg_in),
        .cfg_q_o (cfg_q),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .fin_o   (fin),
        .rej_o   (rej)
    );

    // Operand selection: one candidate per lane width, then a mux.
    for (genvar j = 0; j < NJOB; j++) begin : g_job
        logic [AW-1:0] pick_a [3];
        logic [PW-1:0] pick_b [3];
        logic [AW-1:0] nar_a;
        logic [PW-1:0] nar_b;

        for (genvar w = 0; w < 3; w++) begin : g_w
            localparam int unsigned EW = 8 << w;
            localparam int unsigned NL = VLEN / (2 * EW);
            if (j < NL) begin : g_on
                logic [EW-1:0] ea, eb;
                assign ea = cfg_in.top ? src_a_i[(2*j+1)*EW +: EW]
                                       : src_a_i[(2*j)*EW +: EW];
                assign eb = cfg_in.top ? src_b_i[(2*j+1)*EW +: EW]
                                       : src_b_i[(2*j)*EW +: EW];
                assign pick_a[w] = AW'(ea);
                assign pick_b[w] = (cfg_in.kind == K_SIGNED)
                                 ? {{(PW-EW){eb[EW-1]}}, eb}
                                 : PW'(eb);
            end else begin : g_off
                assign pick_a[w] = '0;
                assign pick_b[w] = '0;
            end
        end

        assign nar_a = AW'(src_a_i[j*8 +: 8]);
        assign nar_b = PW'(src_b_i[j*8 +: 8]);

        always_comb begin
            if (cfg_in.narrow) begin
                job_a[j] = nar_a;
                job_b[j] = nar_b;
            end else begin
                job_a[j] = pick_a[cfg_in.width];
                job_b[j] = pick_b[cfg_in.width];
            end
        end

        wbt_lane #(.AW(AW), .PW(PW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .step_i (step),
            .last_i (last),
            .kind_i (cfg_q.kind),
            .a_i    (job_a[j]),
            .b_i    (job_b[j]),
            .acc_o  (job_acc[j])
        );
    end

    // Product packing: pair i fills bits [2E*i +: 2E].
    always_comb begin
        packed_res = '0;
        if (cfg_q.narrow) begin
            for (int j = 0; j < NJOB; j++) packed_res[j*8 +: 8] = job_acc[j][7:0];
        end else begin
            case (cfg_q.width)
                W8:  for (int j = 0; j < VLEN/16; j++)
                         packed_res[j*16 +: 16] = job_acc[j][15:0];
                W16: for (int j = 0; j < VLEN/32; j++)
                         packed_res[j*32 +: 32] = job_acc[j][31:0];
                default: for (int j = 0; j < VLEN/64; j++)
                         packed_res[j*64 +: 64] = job_acc[j][63:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            undef_q  <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= rej || fin;
            if (rej) begin
                undef_q  <= 1'b1;
                result_q <= '0;
            end else if (fin) begin
                undef_q  <= 1'b0;
                result_q <= packed_res;
            end
        end
    end

    assign done_o   = done_q;
    assign undef_o  = undef_q;
    assign result_o = result_q;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: an undefined encoding never leaves a nonzero result
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (result_o == '0));

    // R11: outputs hold between completions
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rej) && !$past(fin)) |-> $stable(result_o));

endmodule

// File: tb/wbt_mul_bench.sv
`timescale 1ns/100ps
module wbt_mul_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         narrow = 1'b0;
    logic [2:0]   opc = 3'd0;
    logic [1:0]   size = 2'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         done, undef;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wbt_mul #(.VLEN(128)) u_wbt_mul (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .narrow_i (narrow),
        .opc_i    (opc),
        .size_i   (size),
        .src_a_i  (src_a),
        .src_b_i  (src_b),
        .done_o   (done),
        .undef_o  (undef),
        .result_o (result)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", what, got, exp);
        end
    endtask

    // Independent reference decode (widths per R1, R5-R8)
    function automatic void ref_dec(input bit nar, input logic [2:0] op,
                                    input logic [1:0] sz, output bit legal,
                                    output int kind, output int e, output bit top);
        legal = 0; kind = 0; e = 8; top = 0;
        if (nar) begin
            legal = (sz == 0); kind = 0; e = 8;
        end else begin
            top = op[0];
            e = (sz == 3) ? 32 : (sz == 2) ? 16 : 8;
            if (op == 2 || op == 3) begin kind = 0; legal = (sz == 1 || sz == 3); end
            else if (op == 4 || op == 5) begin kind = 1; legal = (sz != 0); end
            else if (op == 6 || op == 7) begin kind = 2; legal = (sz != 0); end
        end
    endfunction

    function automatic logic [63:0] ref_mul(input int kind, input int e,
                                            input logic [63:0] a, input logic [63:0] b);
        logic [63:0] p, sa, sb;
        p = '0;
        if (kind == 0) begin
            for (int j = 0; j < e; j++) if (a[j]) p = p ^ (b << j);
        end else if (kind == 2) begin
            p = a * b;
        end else begin
            sa = a[e-1] ? (a | (~64'd0 << e)) : a;
            sb = b[e-1] ? (b | (~64'd0 << e)) : b;
            p = sa * sb;
        end
        return p;
    endfunction

    function automatic logic [127:0] ref_vec(input bit nar, input logic [2:0] op,
                                             input logic [1:0] sz,
                                             input logic [127:0] a, input logic [127:0] b);
        bit legal, top; int kind, e;
        logic [127:0] r;
        logic [63:0] ea, eb, p, m;
        r = '0;
        ref_dec(nar, op, sz, legal, kind, e, top);
        if (!legal) return r;
        if (nar) begin
            for (int i = 0; i < 16; i++) begin
                p = ref_mul(0, 8, 64'(a[i*8 +: 8]), 64'(b[i*8 +: 8]));
                r[i*8 +: 8] = p[7:0];
            end
        end else begin
            m = (e == 32) ? ~64'd0 : ((64'd1 << (2*e)) - 1);
            for (int i = 0; i < 128/(2*e); i++) begin
                ea = 64'((a >> ((2*i + top) * e)) & ((128'd1 << e) - 1));
                eb = 64'((b >> ((2*i + top) * e)) & ((128'd1 << e) - 1));
                p  = ref_mul(kind, e, ea, eb) & m;
                r  = r | (128'(p) << (i * 2 * e));
            end
        end
        return r;
    endfunction

    // Issue one operation and check result, flag, latency and pulse shape.
    task automatic run_op(input bit nar, input logic [2:0] op, input logic [1:0] sz,
                          input logic [127:0] a, input logic [127:0] b, input string tag);
        bit legal, top; int kind, e, cyc, exp_cyc;
        logic [127:0] exp, held;
        ref_dec(nar, op, sz, legal, kind, e, top);
        exp     = ref_vec(nar, op, sz, a, b);
        exp_cyc = legal ? e + 1 : 0;
        @(negedge clk);
        narrow = nar; opc = op; size = sz; src_a = a; src_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        src_a = ~a; src_b = ~b;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(posedge clk); @(negedge clk); cyc++;
        end
        check(cyc == exp_cyc, {tag, " R9 R10 latency"}, 128'(cyc), 128'(exp_cyc));
        check(result == exp, {tag, " result"}, result, exp);
        check(undef == !legal, {tag, " R10 undef flag"}, 128'(undef), 128'(!legal));
        held = result;
        @(posedge clk); @(negedge clk);
        check(!done && result == held, {tag, " R11 pulse/hold"}, result, held);
    endtask

    task automatic t_reset();
        check(done == 0, "R12 reset done", 128'(done), 0);
        check(undef == 0, "R12 reset undef", 128'(undef), 0);
        check(result == 0, "R12 reset result", result, 0);
    endtask

    task automatic t_undefined();
        logic [127:0] a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        run_op(0, 3'd0, 2'd1, a, ~a, "R1 R10 opc0");
        run_op(0, 3'd1, 2'd3, a, ~a, "R1 R10 opc1");
        run_op(0, 3'd2, 2'd2, a, ~a, "R7 poly size2");
        run_op(0, 3'd3, 2'd0, a, ~a, "R7 poly size0");
        run_op(0, 3'd4, 2'd0, a, ~a, "R5 R6 signed size0");
        run_op(0, 3'd7, 2'd0, a, ~a, "R6 unsigned size0");
        run_op(1, 3'd2, 2'd1, a, ~a, "R8 narrow size1");
    endtask

    task automatic t_poly();
        run_op(0, 3'd2, 2'd1, 128'hff00_ff80_0102_0304_a5a5_5a5a_ffff_8181,
               128'hff11_ff77_8090_a0b0_c3c3_3c3c_ffff_7f7f, "R1 R2 R3 R4 R7 poly bottom8");
        run_op(0, 3'd3, 2'd1, 128'hff00_ff80_0102_0304_a5a5_5a5a_ffff_8181,
               128'hff11_ff77_8090_a0b0_c3c3_3c3c_ffff_7f7f, "R2 R4 R7 poly top8");
        run_op(0, 3'd3, 2'd3, 128'hffff_ffff_8000_0001_1234_5678_dead_beef,
               128'hffff_ffff_ffff_fffe_0f0f_f0f0_cafe_babe, "R2 R3 R4 R7 poly top32");
        run_op(0, 3'd2, 2'd3, 128'hffff_ffff_8000_0001_1234_5678_dead_beef,
               128'hffff_ffff_ffff_fffe_0f0f_f0f0_cafe_babe, "R4 R7 poly bottom32");
    endtask

    task automatic t_signed();
        run_op(0, 3'd4, 2'd2, 128'h8000_7fff_ffff_0001_8000_1234_fff0_0003,
               128'h8000_8000_ffff_7fff_7fff_edcc_0010_fffd, "R1 R2 R5 signed bottom16");
        run_op(0, 3'd5, 2'd1, 128'h80ff_7f80_01ff_ff7f_8080_0102_fe03_1234,
               128'h8080_8001_7fff_ff80_7f7f_fe02_0203_5678, "R2 R5 signed top8");
        run_op(0, 3'd4, 2'd3, 128'h0000_0001_8000_0000_7fff_ffff_8000_0000,
               128'hffff_ffff_8000_0000_8000_0000_8000_0000, "R3 R5 signed bottom32");
    endtask

    task automatic t_unsigned();
        run_op(0, 3'd7, 2'd1, 128'hff00_ff00_ff00_ff00_ff00_ff00_ff00_ff00,
               128'hff01_ff02_ff03_ff04_ff05_ff06_ff07_ff08, "R1 R2 R6 unsigned top8");
        run_op(0, 3'd6, 2'd3, 128'h1111_1111_ffff_ffff_2222_2222_ffff_ffff,
               128'h3333_3333_ffff_ffff_4444_4444_8000_0001, "R3 R6 unsigned bottom32");
        run_op(0, 3'd6, 2'd2, 128'hffff_ffff_1234_5678_0000_ffff_abcd_0001,
               128'hffff_0002_9abc_def0_ffff_ffff_4321_ffff, "R6 unsigned bottom16");
    endtask

    task automatic t_narrow();
        run_op(1, 3'd0, 2'd0, 128'hff80_0102_0304_a5a5_5a5a_ffff_8181_7e01,
               128'hff11_ff77_8090_a0b0_c3c3_3c3c_ffff_7f55, "R8 narrow opc0");
        run_op(1, 3'd7, 2'd0, 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0,
               128'hf0e1_d2c3_b4a5_9687_7869_5a4b_3c2d_1e0f, "R8 narrow opc7");
    endtask

    task automatic t_busy();
        logic [127:0] a = 128'hdead_beef_0000_0003_ffff_ffff_1234_5678;
        logic [127:0] b = 128'h0000_0002_cafe_f00d_ffff_ffff_0000_0010;
        logic [127:0] exp = ref_vec(0, 3'd6, 2'd3, a, b);
        int cyc;
        @(negedge clk);
        narrow = 0; opc = 3'd6; size = 2'd3; src_a = a; src_b = b; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(posedge clk); @(negedge clk); cyc++;
            if (cyc == 3) begin
                opc = 3'd0; src_a = ~a; src_b = a; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(cyc == 33, "R11 busy start latency", 128'(cyc), 128'd33);
        check(result == exp, "R11 busy start result", result, exp);
        check(undef == 0, "R11 busy start undef", 128'(undef), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_undefined();
        t_poly();
        t_signed();
        t_unsigned();
        t_narrow();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule